// File: doc/BRIEF.md
# Segmented MMU translator

The block turns a 32-bit virtual address into a physical address for a machine whose translation tables are held on chip. There are two of them: a segment map and a page map. A virtual address is rejected when its top three bits do not sign-extend. If it passes that check, the current context and the virtual segment number select a segment-map entry. That entry names a page group. The group and the virtual page number then select a page entry in the page map.

The page entry is checked for validity, write permission and supervisor restriction, in that order. On success the block reports the physical address, the non-cacheable flag and the space type. It also writes the entry back with its used bit set, and with its modified bit set on a write. On a fault it reports a 2-bit code instead and leaves the page map untouched.

A simple host port loads and inspects both maps whenever no translation is running. Each translation takes a fixed number of cycles. New requests are held off through a ready signal.

Top module: `mmu_xlate`

## Requirements
- R1: An address whose bits 31:29 are neither 000 nor 111 faults with code 0 (hole). This outranks every other fault, and the page map is not modified.
- R2: The segment-map index is {context, va[18 +: SEG_W]}, with the context in the upper bits. The entry read there gives a page group of GRP_W bits. The page-map index is {group, va[17:12]}, with the group in the upper bits.
- R3: Page entry checks: bit 31 clear gives code 1 (invalid). Otherwise a write with bit 30 clear gives code 2 (write-protect). Otherwise a user access with bit 29 set gives code 3 (supervisor-only). The first check that applies decides the code.
- R4: On success paddr_o equals {entry bits 18:0, va[11:0]}. On a fault paddr_o is zero.
- R5: On success nc_o equals entry bit 28 and space_o equals entry bits 27:26 (0 memory, 1 I/O, 2 narrow external bus, 3 wide external bus). On a fault both are zero.
- R6: A successful access writes the entry back with bit 25 (used) set. A successful write also sets bit 24 (modified). All other bits are kept. A faulting access leaves the page map unchanged.
- R7: done_o is a one-cycle pulse in the third cycle after the cycle in which a request is accepted. req_ready_o is low in the two cycles in between.
- R8: The host port acts only when host_ready_o is high, which is whenever no translation is in progress. host_sel_i picks the map: 0 for the segment map, 1 for the page map. A write updates the addressed entry. A read returns the entry, zero-extended, on host_rdata_o with host_rvalid_o high in the next cycle.
- R9: While idle, a host access wins over a translation request: req_ready_o is low whenever host_valid_i is high.
- R10: After reset done_o and host_rvalid_o are low, and req_ready_o and host_ready_o are high while host_valid_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Request accepted this cycle when high with req_valid_i |
| req_va_i | input | 32 | Virtual address |
| req_ctx_i | input | CTX_W | Current context |
| req_write_i | input | 1 | Access is a write |
| req_user_i | input | 1 | Access is from user mode |
| done_o | output | 1 | Result valid pulse |
| fault_o | output | 1 | Translation faulted |
| fault_code_o | output | 2 | 0 hole, 1 invalid, 2 write-protect, 3 supervisor-only |
| paddr_o | output | 31 | Physical address |
| nc_o | output | 1 | Access must bypass caches |
| space_o | output | 2 | Space type of the page |
| host_valid_i | input | 1 | Host map access |
| host_ready_o | output | 1 | Host access accepted when high |
| host_write_i | input | 1 | Host access is a write |
| host_sel_i | input | 1 | 0 segment map, 1 page map |
| host_addr_i | input | HA_W | Entry index |
| host_wdata_i | input | 32 | Write data (segment map takes the low GRP_W bits) |
| host_rvalid_o | output | 1 | Host read data valid |
| host_rdata_o | output | 32 | Host read data |

## Verification
The bench builds the block with CTX_W=1, SEG_W=2 and GRP_W=2. That gives an 8-entry segment map and a 256-entry page map, so every entry of both maps can be loaded, translated through and read back. In this configuration several segments alias onto the same page group. As a result, the used and modified bits written back by one access are seen by later accesses through other contexts and segments. The bench runs every context, segment and page with all four write/user combinations and every hole pattern. It also checks that a request is stalled by a coincident host write.

// File: rtl/mmu_pkg.sv
`timescale 1ns/1ps
package mmu_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SEG, ST_PTE} mmu_state_e;

  localparam logic [1:0] FLT_HOLE    = 2'd0;
  localparam logic [1:0] FLT_INVALID = 2'd1;
  localparam logic [1:0] FLT_WPROT   = 2'd2;
  localparam logic [1:0] FLT_SUPER   = 2'd3;

  localparam int OFF_W   = 12;
  localparam int VPN_LSB = 12;
  localparam int VPN_W   = 6;
  localparam int SEG_LSB = 18;
  localparam int PFN_W   = 19;
  localparam int PA_W    = PFN_W + OFF_W;

  localparam int E_VALID = 31;
  localparam int E_WR    = 30;
  localparam int E_SUP   = 29;
  localparam int E_NC    = 28;
  localparam int E_SP_HI = 27;
  localparam int E_SP_LO = 26;
  localparam int E_USED  = 25;
  localparam int E_MOD   = 24;
endpackage

// File: rtl/mmu_ram.sv
`timescale 1ns/1ps
module mmu_ram #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [2**AW];

  // read data only moves on a read, so a writeback leaves it alone
  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (we_i) mem_q[addr_i] <= wdata_i;
      else      rdata_o       <= mem_q[addr_i];
    end
  end
endmodule

// File: rtl/mmu_pte_check.sv
`timescale 1ns/1ps
module mmu_pte_check
  import mmu_pkg::*;
(
  input  logic             hole_i,
  input  logic             write_i,
  input  logic             user_i,
  input  logic [31:0]      pte_i,
  input  logic [OFF_W-1:0] off_i,
  output logic             fault_o,
  output logic [1:0]       code_o,
  output logic [31:0]      pte_upd_o,
  output logic [PA_W-1:0]  paddr_o,
  output logic             nc_o,
  output logic [1:0]       space_o
);
  always_comb begin
    fault_o   = 1'b1;
    code_o    = FLT_HOLE;
    pte_upd_o = pte_i;
    paddr_o   = '0;
    nc_o      = 1'b0;
    space_o   = 2'b00;
    if (hole_i)                        code_o = FLT_HOLE;
    else if (!pte_i[E_VALID])          code_o = FLT_INVALID;
    else if (write_i && !pte_i[E_WR])  code_o = FLT_WPROT;
    else if (user_i && pte_i[E_SUP])   code_o = FLT_SUPER;
    else begin
      fault_o           = 1'b0;
      pte_upd_o[E_USED] = 1'b1;
      if (write_i) pte_upd_o[E_MOD] = 1'b1;
      paddr_o = {pte_i[PFN_W-1:0], off_i};
      nc_o    = pte_i[E_NC];
      space_o = pte_i[E_SP_HI:E_SP_LO];
    end
  end
endmodule

// File: rtl/mmu_xlate.sv
`timescale 1ns/1ps
module mmu_xlate
  import mmu_pkg::*;
#(
  parameter int CTX_W = 3,
  parameter int SEG_W = 8,   // 12 on a full-size map
  parameter int GRP_W = 5,   // 7 on a full-size map
  localparam int SM_AW = CTX_W + SEG_W,
  localparam int PM_AW = GRP_W + VPN_W,
  localparam int HA_W  = (SM_AW > PM_AW) ? SM_AW : PM_AW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [31:0]      req_va_i,
  input  logic [CTX_W-1:0] req_ctx_i,
  input  logic             req_write_i,
  input  logic             req_user_i,
  output logic             done_o,
  output logic             fault_o,
  output logic [1:0]       fault_code_o,
  output logic [PA_W-1:0]  paddr_o,
  output logic             nc_o,
  output logic [1:0]       space_o,
  input  logic             host_valid_i,
  output logic             host_ready_o,
  input  logic             host_write_i,
  input  logic             host_sel_i,
  input  logic [HA_W-1:0]  host_addr_i,
  input  logic [31:0]      host_wdata_i,
  output logic             host_rvalid_o,
  output logic [31:0]      host_rdata_o
);
  mmu_state_e state_q;
  logic idle, acc, host_acc, req_hole;
  logic hole_q, wr_q, user_q, hsel_q, hrv_q;
  logic [VPN_W-1:0] vpn_q;
  logic [OFF_W-1:0] off_q;
  logic [PM_AW-1:0] pidx_q, pidx_seg;

  logic             sm_en, sm_we;
  logic [SM_AW-1:0] sm_addr;
  logic [GRP_W-1:0] sm_rdata;
  logic             pm_en, pm_we, pg_wb;
  logic [PM_AW-1:0] pm_addr;
  logic [31:0]      pm_wdata, pm_rdata;

  logic             chk_fault, chk_nc;
  logic [1:0]       chk_code, chk_space;
  logic [31:0]      chk_pte;
  logic [PA_W-1:0]  chk_paddr;

  logic             done_q, fault_q, nc_q;
  logic [1:0]       code_q, space_q;
  logic [PA_W-1:0]  paddr_q;
  logic             unused_va, unused_haddr;

  assign unused_va    = ^req_va_i;
  assign unused_haddr = ^host_addr_i;

  assign idle         = (state_q == ST_IDLE);
  assign host_ready_o = idle;
  assign req_ready_o  = idle & ~host_valid_i;
  assign host_acc     = idle & host_valid_i;
  assign acc          = req_valid_i & req_ready_o;
  assign req_hole     = (req_va_i[31:29] != 3'b000) && (req_va_i[31:29] != 3'b111);

  // segment map: host at idle, else lookup on accept
  assign sm_en    = (host_acc & ~host_sel_i) | acc;
  assign sm_we    = host_acc & ~host_sel_i & host_write_i;
  assign sm_addr  = host_acc ? host_addr_i[SM_AW-1:0]
                             : {req_ctx_i, req_va_i[SEG_LSB +: SEG_W]};

  mmu_ram #(.AW(SM_AW), .DW(GRP_W)) u_seg_map (
    .clk_i  (clk_i),
    .en_i   (sm_en),
    .we_i   (sm_we),
    .addr_i (sm_addr),
    .wdata_i(host_wdata_i[GRP_W-1:0]),
    .rdata_o(sm_rdata)
  );

  // page map: host at idle, lookup in ST_SEG, writeback in ST_PTE
  assign pidx_seg = {sm_rdata, vpn_q};
  assign pg_wb    = (state_q == ST_PTE) & ~chk_fault;
  assign pm_en    = (host_acc & host_sel_i) | (state_q == ST_SEG) | pg_wb;
  assign pm_we    = (host_acc & host_sel_i & host_write_i) | pg_wb;
  assign pm_addr  = host_acc ? host_addr_i[PM_AW-1:0]
                  : (state_q == ST_SEG) ? pidx_seg : pidx_q;
  assign pm_wdata = host_acc ? host_wdata_i : chk_pte;

  mmu_ram #(.AW(PM_AW), .DW(32)) u_page_map (
    .clk_i  (clk_i),
    .en_i   (pm_en),
    .we_i   (pm_we),
    .addr_i (pm_addr),
    .wdata_i(pm_wdata),
    .rdata_o(pm_rdata)
  );

  mmu_pte_check u_check (
    .hole_i   (hole_q),
    .write_i  (wr_q),
    .user_i   (user_q),
    .pte_i    (pm_rdata),
    .off_i    (off_q),
    .fault_o  (chk_fault),
    .code_o   (chk_code),
    .pte_upd_o(chk_pte),
    .paddr_o  (chk_paddr),
    .nc_o     (chk_nc),
    .space_o  (chk_space)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      hole_q  <= 1'b0;
      wr_q    <= 1'b0;
      user_q  <= 1'b0;
      vpn_q   <= '0;
      off_q   <= '0;
      pidx_q  <= '0;
      hsel_q  <= 1'b0;
      hrv_q   <= 1'b0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      code_q  <= '0;
      paddr_q <= '0;
      nc_q    <= 1'b0;
      space_q <= '0;
    end else begin
      done_q <= 1'b0;
      hrv_q  <= host_acc & ~host_write_i;
      if (host_acc) hsel_q <= host_sel_i;
      unique case (state_q)
        ST_IDLE: if (acc) begin
          state_q <= ST_SEG;
          hole_q  <= req_hole;
          wr_q    <= req_write_i;
          user_q  <= req_user_i;
          vpn_q   <= req_va_i[VPN_LSB +: VPN_W];
          off_q   <= req_va_i[OFF_W-1:0];
        end
        ST_SEG: begin
          state_q <= ST_PTE;
          pidx_q  <= pidx_seg;
        end
        ST_PTE: begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
          fault_q <= chk_fault;
          code_q  <= chk_code;
          paddr_q <= chk_paddr;
          nc_q    <= chk_nc;
          space_q <= chk_space;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o        = done_q;
  assign fault_o       = fault_q;
  assign fault_code_o  = code_q;
  assign paddr_o       = paddr_q;
  assign nc_o          = nc_q;
  assign space_o       = space_q;
  assign host_rvalid_o = hrv_q;
  assign host_rdata_o  = hsel_q ? pm_rdata : 32'(sm_rdata);

  assert_busy_stall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> !req_ready_o);
  assert_done_latency_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> ##2 done_o);
  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_no_wb_on_fault_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PTE && chk_fault) |-> !pm_we);
  assert_wb_marks_used_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pg_wb |-> pm_wdata[E_USED]);
  assert_offset_kept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !fault_o) |-> paddr_o[OFF_W-1:0] == off_q);
  assert_hole_first_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && hole_q) |-> (fault_o && fault_code_o == FLT_HOLE));
  assert_host_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rvalid_o |-> $past(host_ready_o));
  assert_host_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_valid_i |-> !acc);
endmodule

// File: tb/mmu_xlate_test.sv
`timescale 1ns/1ps
module mmu_xlate_test;
  localparam int CW = 1, SW = 2, GW = 2;
  localparam int SM_N = 2**(CW+SW), PM_N = 2**(GW+6);

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic req_valid = 0, req_write = 0, req_user = 0;
  logic [31:0] req_va = '0;
  logic [CW-1:0] req_ctx = '0;
  logic host_valid = 0, host_write = 0, host_sel = 0;
  logic [7:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic req_ready, done, fault, nc, host_ready, host_rvalid;
  logic [1:0] code, space;
  logic [30:0] paddr;
  logic [31:0] host_rdata;

  mmu_xlate #(.CTX_W(CW), .SEG_W(SW), .GRP_W(GW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_va_i(req_va),
    .req_ctx_i(req_ctx), .req_write_i(req_write), .req_user_i(req_user),
    .done_o(done), .fault_o(fault), .fault_code_o(code), .paddr_o(paddr),
    .nc_o(nc), .space_o(space),
    .host_valid_i(host_valid), .host_ready_o(host_ready), .host_write_i(host_write),
    .host_sel_i(host_sel), .host_addr_i(host_addr), .host_wdata_i(host_wdata),
    .host_rvalid_o(host_rvalid), .host_rdata_o(host_rdata)
  );

  int n_chk = 0, n_fail = 0;
  logic [GW-1:0] segm [SM_N];
  logic [31:0]   pgm  [PM_N];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_pte(input int i);
    logic [31:0] e;
    int pfn;
    pfn = (i * 2654435 + 17) & 32'h7FFFF;
    e = '0;
    e[31] = (i % 5) != 0;
    e[30] = i[0];
    e[29] = i[1] ^ i[3];
    e[28] = i[2];
    e[27:26] = 2'(i >> 4);
    e[18:0] = 19'(pfn);
    return e;
  endfunction

  task automatic host_wr(input logic sel, input int addr, input logic [31:0] d);
    @(negedge clk);
    host_valid = 1; host_write = 1; host_sel = sel; host_addr = 8'(addr); host_wdata = d;
    @(posedge clk);
    @(negedge clk);
    host_valid = 0; host_write = 0;
  endtask

  task automatic host_rd(input logic sel, input int addr, output logic [31:0] d);
    @(negedge clk);
    host_valid = 1; host_write = 0; host_sel = sel; host_addr = 8'(addr);
    @(posedge clk);
    @(negedge clk);
    host_valid = 0;
    chk(host_rvalid === 1'b1, "R8 rvalid", 64'(host_rvalid), 64'd1);
    d = host_rdata;
  endtask

  // expected result from the model, updating it on success
  task automatic expect_result(input logic [31:0] va, input logic [CW-1:0] ctx,
                               input logic wr, input logic usr);
    logic hole, efault, enc;
    logic [1:0] ecode, esp;
    logic [30:0] epa;
    logic [GW-1:0] grp;
    int pidx;
    logic [31:0] e;
    hole = !(va[31:29] == 3'b000 || va[31:29] == 3'b111);
    grp  = segm[{ctx, va[19:18]}];
    pidx = int'({grp, va[17:12]});
    e = pgm[pidx];
    efault = 1; ecode = 0; epa = '0; enc = 0; esp = 0;
    if (hole) ecode = 2'd0;
    else if (!e[31]) ecode = 2'd1;
    else if (wr && !e[30]) ecode = 2'd2;
    else if (usr && e[29]) ecode = 2'd3;
    else begin
      efault = 0; epa = {e[18:0], va[11:0]}; enc = e[28]; esp = e[27:26];
      pgm[pidx] = e | 32'h0200_0000 | (wr ? 32'h0100_0000 : 32'h0);
    end
    chk(done === 1'b1, "R7 done", 64'(done), 64'd1);
    if (hole) chk({fault, code} === {1'b1, 2'd0}, "R1 hole code", 64'({fault, code}), 64'({1'b1, 2'd0}));
    else      chk({fault, code} === {efault, ecode}, "R3 fault code", 64'({fault, code}), 64'({efault, ecode}));
    chk(paddr === epa, "R2 R4 paddr", 64'(paddr), 64'(epa));
    chk({nc, space} === {enc, esp}, "R5 nc/space", 64'({nc, space}), 64'({enc, esp}));
  endtask

  task automatic xlate(input logic [31:0] va, input logic [CW-1:0] ctx,
                       input logic wr, input logic usr);
    @(negedge clk);
    req_valid = 1; req_va = va; req_ctx = ctx; req_write = wr; req_user = usr;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready && !host_ready, "R7 R8 busy stall", 64'({req_ready, host_ready}), 64'd0);
    @(negedge clk);
    chk(!done && !req_ready, "R7 no early done", 64'({done, req_ready}), 64'd0);
    @(negedge clk);
    expect_result(va, ctx, wr, usr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk({done, host_rvalid, req_ready, host_ready} === 4'b0011, "R10 reset",
        64'({done, host_rvalid, req_ready, host_ready}), 64'b0011);

    for (int i = 0; i < SM_N; i++) begin
      segm[i] = GW'(i * 3 + 1);
      host_wr(1'b0, i, 32'(segm[i]) | 32'hFFFF_FFF0);
    end
    for (int i = 0; i < PM_N; i++) begin
      pgm[i] = mk_pte(i);
      host_wr(1'b1, i, pgm[i]);
    end
    for (int i = 0; i < SM_N; i++) begin
      host_rd(1'b0, i, d);
      chk(d === 32'(segm[i]), "R8 seg readback", 64'(d), 64'(segm[i]));
    end
    host_rd(1'b1, 77, d);
    chk(d === pgm[77], "R8 page readback", 64'(d), 64'(pgm[77]));

    // main sweep: all contexts, segments, pages, write/user combos
    for (int c = 0; c < 2; c++)
      for (int s = 0; s < 4; s++)
        for (int p = 0; p < 64; p++)
          for (int m = 0; m < 4; m++)
            xlate({(p[0] ? 3'b111 : 3'b000), 9'(p * 37 + s), 2'(s), 6'(p), 12'(p * 91 + m * 7 + c)},
                  CW'(c), m[0], m[1]);

    // R7 done lasts a single cycle
    @(negedge clk);
    chk(done === 1'b0, "R7 pulse width", 64'(done), 64'd0);

    // R1 hole sweep: write from user mode everywhere in the hole
    for (int t = 1; t < 7; t++)
      for (int si = 0; si < SM_N; si++)
        for (int k = 0; k < 4; k++)
          xlate({3'(t), 9'(t * 5), 2'(si), 6'(k * 21), 12'(k * 333)}, CW'(si >> 2), 1'b1, 1'b1);

    // R9 host write beats a simultaneous request
    @(negedge clk);
    pgm[{segm[0], 6'd5}] = 32'hC5A1_2345;
    host_valid = 1; host_write = 1; host_sel = 1; host_addr = 8'({segm[0], 6'd5});
    host_wdata = 32'hC5A1_2345;
    req_valid = 1; req_va = 32'h0000_5ABC; req_ctx = '0; req_write = 1; req_user = 0;
    #1;
    chk(req_ready === 1'b0, "R9 host priority", 64'(req_ready), 64'd0);
    @(posedge clk);
    @(negedge clk);
    host_valid = 0; host_write = 0;
    #1;
    chk(req_ready === 1'b1, "R9 ready after host", 64'(req_ready), 64'd1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
    @(negedge clk);
    expect_result(32'h0000_5ABC, '0, 1'b1, 1'b0);

    // R6 page map contents after all writebacks and faults
    for (int i = 0; i < PM_N; i++) begin
      host_rd(1'b1, i, d);
      chk(d === pgm[i], "R6 writeback", 64'(d), 64'(pgm[i]));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule